// File: doc/BRIEF.md
# Precision-Configurable Neuron Slice

This block evaluates one layer of a small neural network at a time. It holds a bank of processing elements. On every accumulate step, one 16-bit input word goes to all of them at once. Each element multiplies the word by its own 16-bit weight, which is supplied from outside the block on that step, and adds the result into a private 32-bit neuron sum. A packing-mode input decides how each 16-bit word is read: as sixteen 1-bit values, four 4-bit values, two 8-bit values or one 16-bit value. The products of the sub-values that sit in the same position of the input word and the weight are added together before they go into the sum.

When a layer is finished, a start pulse sends every neuron sum, one per cycle in element order, through a single shared piecewise-linear threshold stage. That stage has four programmable segments and produces 16-bit outputs. Each output comes with a valid strobe and its element index. It is also kept in an internal feedback store. A later layer can select any stored word as its input word through an address, without the data leaving the block. Weight storage, learning and cascading of several slices are left to the surrounding logic.

Top module: `prec_neuron_slice`

## Requirements
- R1: Synchronous active-high reset clears all sums, drops `busy` and `out_valid`, and loads every threshold segment with breakpoint 0, slope 256 (1.0 with 8 fraction bits) and offset 0. The threshold stage then passes sums through unchanged, clipped to 16 bits.
- R2: With `mode` = 3, a cycle with `step` high adds the signed 16x16 product of the input word and element i's weight `weights[16*i+15:16*i]` to sum i. Without `step` or `clr`, the sums hold.
- R3: With `mode` = 2, the word is read as two signed bytes (bits 7:0 and 15:8). The sum gains the two byte products of matching positions, added together.
- R4: With `mode` = 1, the word is read as four signed nibbles (bits 4j+3:4j). The sum gains the four nibble products of matching positions, added together.
- R5: With `mode` = 0, the 16 bits are unsigned 0/1 values. The sum gains the number of bit positions where both the input and the weight are 1.
- R6: A sum that would pass the 32-bit signed range is held at 2147483647 or -2147483648 and does not wrap.
- R7: `clr` zeroes every sum and takes priority over a `step` in the same cycle.
- R8: A threshold result uses the highest segment k whose breakpoint is at or below the sum, or segment 0 when no breakpoint is at or below it. The result is ((sum - brk_k) * slope_k) >>> 8, plus offset_k, clipped to [-32768, 32767]. A cycle with `cfg_we` high writes the segment named by `cfg_seg`.
- R9: A `thr_start` pulse while idle raises `busy` after the next edge. `out_valid` then rises one cycle later and stays high for 16 consecutive cycles, with `out_idx` counting 0 to 15. `busy` falls in the same cycle as the last result.
- R10: While `busy` is high, `step` and `clr` have no effect on the sums.
- R11: With `use_fb` high, the input word for a step is the most recent threshold output of element `fb_addr`, in place of `in_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all neuron sums (start of layer) |
| step | input | 1 | Accumulate the current input word and weights |
| mode | input | 2 | Packing: 0 = 1-bit, 1 = 4-bit, 2 = 8-bit, 3 = 16-bit |
| in_word | input | 16 | External input word |
| use_fb | input | 1 | Take the input word from the feedback store |
| fb_addr | input | 4 | Feedback store entry used when `use_fb` is high |
| weights | input | 256 | One 16-bit weight per element, element i at bits 16i+15:16i |
| thr_start | input | 1 | Start the threshold pass over all sums |
| cfg_we | input | 1 | Write one threshold segment |
| cfg_seg | input | 2 | Segment being written |
| cfg_brk | input | 32 | Segment breakpoint, signed |
| cfg_slope | input | 16 | Segment slope, signed, 8 fraction bits |
| cfg_ofs | input | 16 | Segment offset, signed |
| busy | output | 1 | Threshold pass in progress |
| out_valid | output | 1 | Threshold result present |
| out_idx | output | 4 | Element index of the result |
| out_word | output | 16 | Thresholded output |

## Verification
Each packing mode gets words whose fields carry mixed signs, with weights that differ per element. A wrong lane boundary, a lost sign extension or an unsigned multiply in the wrong mode therefore changes at least one of the 16 sums. The 1-bit mode uses nested weight masks, so each element's count is different. The saturation test pushes even elements up and odd elements down with products of 2^30. In the clipped identity output, wrapping and clamping land on opposite rails. A four-segment curve with rising, falling and clipped sections tests breakpoint selection on sums that cover the whole range. Feedback steps address two different stored outputs to show that the word is taken from the store. Steps and clears driven during a pass must leave both that pass and a repeat pass unchanged.

// File: rtl/npsl_pkg.sv
package npsl_pkg;

  localparam int WORD_W = 16;
  localparam int ACC_W  = 32;
  localparam int NIB_N  = WORD_W / 4;
  localparam int BYTE_N = WORD_W / 8;

  typedef enum logic [1:0] {
    PK_1B  = 2'd0,
    PK_4B  = 2'd1,
    PK_8B  = 2'd2,
    PK_16B = 2'd3
  } pack_e;

  typedef struct packed {
    logic signed [ACC_W-1:0]  brk;
    logic signed [WORD_W-1:0] slope;
    logic signed [WORD_W-1:0] ofs;
  } seg_t;

endpackage

// File: rtl/npsl_mac.sv
module npsl_mac
  import npsl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr,
  input  pack_e                   mode,
  input  logic [WORD_W-1:0]       x,
  input  logic [WORD_W-1:0]       w,
  output logic signed [ACC_W-1:0] acc
);
  localparam int PROD_W = 2 * WORD_W;
  localparam int ONES_W = $clog2(WORD_W + 1);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [7:0]        p4 [NIB_N];
  logic signed [15:0]       p8 [BYTE_N];
  logic signed [PROD_W-1:0] p16;
  logic [ONES_W-1:0]        ones;
  logic signed [PROD_W-1:0] dot;
  logic signed [ACC_W:0]    wide;

  // Lane products: sign-extend each field to the product width first
  for (genvar j = 0; j < NIB_N; j++) begin : g_nib
    assign p4[j] = $signed({{4{x[4*j+3]}}, x[4*j +: 4]}) *
                   $signed({{4{w[4*j+3]}}, w[4*j +: 4]});
  end

  for (genvar j = 0; j < BYTE_N; j++) begin : g_byte
    assign p8[j] = $signed({{8{x[8*j+7]}}, x[8*j +: 8]}) *
                   $signed({{8{w[8*j+7]}}, w[8*j +: 8]});
  end

  assign p16 = $signed({{WORD_W{x[WORD_W-1]}}, x}) *
               $signed({{WORD_W{w[WORD_W-1]}}, w});

  // 1-bit lanes: unsigned AND products, i.e. a popcount
  always_comb begin
    ones = '0;
    for (int b = 0; b < WORD_W; b++) begin
      ones = ones + ONES_W'(x[b] & w[b]);
    end
  end

  always_comb begin
    dot = '0;
    unique case (mode)
      PK_1B: dot = PROD_W'(ones);
      PK_4B: begin
        for (int j = 0; j < NIB_N; j++) dot = dot + PROD_W'(p4[j]);
      end
      PK_8B: begin
        for (int j = 0; j < BYTE_N; j++) dot = dot + PROD_W'(p8[j]);
      end
      default: dot = p16;
    endcase
  end

  assign wide = (ACC_W+1)'(acc) + (ACC_W+1)'(dot);

  // Saturating accumulate, clear has priority
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      if (wide[ACC_W] != wide[ACC_W-1]) begin
        acc <= wide[ACC_W] ? ACC_MIN : ACC_MAX;
      end else begin
        acc <= wide[ACC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/npsl_pwl.sv
module npsl_pwl
  import npsl_pkg::*;
#(
  parameter int SEG_N  = 4,
  parameter int FRAC_W = 8,
  parameter int SEL_W  = $clog2(SEG_N)
)
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [ACC_W-1:0]         cfg_brk,
  input  logic [WORD_W-1:0]        cfg_slope,
  input  logic [WORD_W-1:0]        cfg_ofs,
  input  logic signed [ACC_W-1:0]  sum,
  output logic [WORD_W-1:0]        y
);
  localparam int PW = ACC_W + WORD_W + 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'(2**(WORD_W-1) - 1);
  localparam logic signed [PW-1:0] SAT_LO = -(PW'(2**(WORD_W-1)));
  localparam logic [WORD_W-1:0]    UNITY  = WORD_W'(1 << FRAC_W);

  seg_t segs [SEG_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SEG_N; k++) begin
        segs[k] <= '{brk: '0, slope: UNITY, ofs: '0};
      end
    end else if (cfg_we) begin
      segs[cfg_sel] <= '{brk: cfg_brk, slope: cfg_slope, ofs: cfg_ofs};
    end
  end

  logic [SEL_W-1:0]      pick;
  seg_t                  cur;
  logic signed [ACC_W:0] diff;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  tot;

  always_comb begin
    pick = '0;
    for (int k = 1; k < SEG_N; k++) begin
      if (sum >= $signed(segs[k].brk)) pick = SEL_W'(k);
    end
    cur  = segs[pick];
    diff = (ACC_W+1)'(sum) - (ACC_W+1)'($signed(cur.brk));
    prod = PW'(diff) * PW'($signed(cur.slope));
    tot  = (prod >>> FRAC_W) + PW'($signed(cur.ofs));
    if (tot > SAT_HI) begin
      y = SAT_HI[WORD_W-1:0];
    end else if (tot < SAT_LO) begin
      y = SAT_LO[WORD_W-1:0];
    end else begin
      y = tot[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/npsl_seq.sv
module npsl_seq #(
  parameter int NUM_PE = 16,
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(NUM_PE)
)
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] thr_y,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [WORD_W-1:0] out_word
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PE - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_word  <= '0;
    end else begin
      out_valid <= busy;
      if (busy) begin
        out_word <= thr_y;
        out_idx  <= idx;
        if (idx == LAST) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end

endmodule

// File: rtl/prec_neuron_slice.sv
module prec_neuron_slice
  import npsl_pkg::*;
#(
  parameter int NUM_PE = 16,
  parameter int SEG_N  = 4,
  parameter int FRAC_W = 8,
  localparam int IDX_W = $clog2(NUM_PE),
  localparam int SEL_W = $clog2(SEG_N)
)
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     step,
  input  logic [1:0]               mode,
  input  logic [WORD_W-1:0]        in_word,
  input  logic                     use_fb,
  input  logic [IDX_W-1:0]         fb_addr,
  input  logic [NUM_PE*WORD_W-1:0] weights,
  input  logic                     thr_start,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_seg,
  input  logic [ACC_W-1:0]         cfg_brk,
  input  logic [WORD_W-1:0]        cfg_slope,
  input  logic [WORD_W-1:0]        cfg_ofs,
  output logic                     busy,
  output logic                     out_valid,
  output logic [IDX_W-1:0]         out_idx,
  output logic [WORD_W-1:0]        out_word
);
  logic                    acc_en;
  logic                    acc_clr;
  pack_e                   mode_e;
  logic [WORD_W-1:0]       x_word;
  logic [WORD_W-1:0]       thr_y;
  logic [IDX_W-1:0]        cur_idx;
  logic [WORD_W-1:0]       fb_mem [NUM_PE];
  logic signed [ACC_W-1:0] acc_arr [NUM_PE];
  logic [NUM_PE*ACC_W-1:0] acc_bus;

  // Sums are frozen during a threshold pass
  assign acc_en  = step & ~busy;
  assign acc_clr = clr & ~busy;
  assign mode_e  = pack_e'(mode);
  assign x_word  = use_fb ? fb_mem[fb_addr] : in_word;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    npsl_mac u_mac (
      .clk  (clk),
      .rst  (rst),
      .en   (acc_en),
      .clr  (acc_clr),
      .mode (mode_e),
      .x    (x_word),
      .w    (weights[g*WORD_W +: WORD_W]),
      .acc  (acc_arr[g])
    );
    assign acc_bus[g*ACC_W +: ACC_W] = acc_arr[g];
  end

  npsl_pwl #(
    .SEG_N  (SEG_N),
    .FRAC_W (FRAC_W),
    .SEL_W  (SEL_W)
  ) u_pwl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_seg),
    .cfg_brk   (cfg_brk),
    .cfg_slope (cfg_slope),
    .cfg_ofs   (cfg_ofs),
    .sum       (acc_arr[cur_idx]),
    .y         (thr_y)
  );

  npsl_seq #(
    .NUM_PE (NUM_PE),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (thr_start),
    .thr_y     (thr_y),
    .busy      (busy),
    .idx       (cur_idx),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_word  (out_word)
  );

  // Feedback store: one synchronous write port, written as each result leaves
  always_ff @(posedge clk) begin
    if (busy) fb_mem[cur_idx] <= thr_y;
  end

endmodule

// File: rtl/npsl_chk.sv
module npsl_chk #(
  parameter int NUM_PE = 16,
  parameter int ACC_W  = 32,
  parameter int IDX_W  = 4
)
(
  input logic                    clk,
  input logic                    rst,
  input logic                    step,
  input logic                    clr,
  input logic                    busy,
  input logic                    out_valid,
  input logic [IDX_W-1:0]        out_idx,
  input logic [NUM_PE*ACC_W-1:0] acc_bus
);

  AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(acc_bus)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr && !busy) |=> (acc_bus == '0)); // R7

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy)); // R9

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_idx == '0)); // R9

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_idx == IDX_W'($past(out_idx) + 1'b1))); // R9

  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(acc_bus)); // R10

endmodule

bind prec_neuron_slice npsl_chk #(
  .NUM_PE (NUM_PE),
  .ACC_W  (npsl_pkg::ACC_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .clr       (clr),
  .busy      (busy),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .acc_bus   (acc_bus)
);

// File: tb/prec_neuron_slice_test.sv
module prec_neuron_slice_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         step = 1'b0;
  logic [1:0]   mode = 2'd3;
  logic [15:0]  in_word = '0;
  logic         use_fb = 1'b0;
  logic [3:0]   fb_addr = '0;
  logic [255:0] weights = '0;
  logic         thr_start = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_seg = '0;
  logic [31:0]  cfg_brk = '0;
  logic [15:0]  cfg_slope = '0;
  logic [15:0]  cfg_ofs = '0;
  logic         busy;
  logic         out_valid;
  logic [3:0]   out_idx;
  logic [15:0]  out_word;

  int n_chk = 0;
  int n_err = 0;

  longint m_acc [16];
  logic [15:0] m_fb [16];
  longint m_brk [4];
  longint m_slope [4];
  longint m_ofs [4];

  always #5 clk = ~clk;

  prec_neuron_slice uut (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .mode(mode),
    .in_word(in_word), .use_fb(use_fb), .fb_addr(fb_addr), .weights(weights),
    .thr_start(thr_start), .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_brk(cfg_brk),
    .cfg_slope(cfg_slope), .cfg_ofs(cfg_ofs), .busy(busy), .out_valid(out_valid),
    .out_idx(out_idx), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_dot(input int md, input logic [15:0] a, input logic [15:0] b);
    int L;
    longint t;
    L = (md == 0) ? 1 : (md == 1) ? 4 : (md == 2) ? 8 : 16;
    t = 0;
    for (int j = 0; j < 16 / L; j++) begin
      longint ea = 0;
      longint eb = 0;
      for (int q = 0; q < L; q++) begin
        ea = ea | (longint'(a[j*L+q]) << q);
        eb = eb | (longint'(b[j*L+q]) << q);
      end
      if (L > 1 && ea >= (longint'(1) << (L-1))) ea = ea - (longint'(1) << L);
      if (L > 1 && eb >= (longint'(1) << (L-1))) eb = eb - (longint'(1) << L);
      t = t + ea * eb;
    end
    return t;
  endfunction

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint ref_pwl(input longint s);
    int k;
    longint v;
    k = 0;
    for (int j = 1; j < 4; j++) if (s >= m_brk[j]) k = j;
    v = ((s - m_brk[k]) * m_slope[k]) >>> 8;
    v = v + m_ofs[k];
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic cfg_write(input int seg, input longint brk, input int slope, input int ofs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 2'(seg); cfg_brk = 32'(brk);
    cfg_slope = 16'(slope); cfg_ofs = 16'(ofs);
    @(negedge clk);
    cfg_we = 1'b0;
    m_brk[seg] = brk; m_slope[seg] = slope; m_ofs[seg] = ofs;
  endtask

  task automatic do_clr(input bit with_step);
    @(negedge clk);
    clr = 1'b1; step = with_step; in_word = 16'h7FFF; use_fb = 1'b0;
    @(negedge clk);
    clr = 1'b0; step = 1'b0;
    for (int i = 0; i < 16; i++) m_acc[i] = 0;
  endtask

  task automatic do_step(input int md, input logic [15:0] wd, input bit fb, input int fa);
    logic [15:0] xw;
    xw = fb ? m_fb[fa] : wd;
    @(negedge clk);
    mode = 2'(md); in_word = wd; use_fb = fb; fb_addr = 4'(fa); step = 1'b1;
    @(negedge clk);
    step = 1'b0; use_fb = 1'b0;
    for (int i = 0; i < 16; i++)
      m_acc[i] = sat32(m_acc[i] + ref_dot(md, xw, weights[i*16 +: 16]));
  endtask

  // Threshold pass; optionally drives step/clr while busy (R10)
  task automatic run_layer(input string req, input bit disturb);
    longint e;
    @(negedge clk);
    thr_start = 1'b1;
    @(negedge clk);
    thr_start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", longint'(busy), 1);
    for (int n = 2; n <= 17; n++) begin
      if (disturb) begin
        step = (n <= 16); clr = (n % 2 == 0); in_word = 16'h7777; mode = 2'd3;
      end
      @(negedge clk);
      e = ref_pwl(m_acc[n-2]);
      chk(out_valid == 1'b1, "R9", "out_valid", longint'(out_valid), 1);
      chk(out_idx == 4'(n-2), "R9", "out_idx", longint'(out_idx), longint'(n-2));
      chk(longint'($signed(out_word)) == e, req, $sformatf("out_word[%0d]", n-2),
          longint'($signed(out_word)), e);
      m_fb[n-2] = 16'(e);
    end
    step = 1'b0; clr = 1'b0;
    chk(busy == 1'b0, "R9", "busy low with last result", longint'(busy), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after pass", longint'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1", "busy at reset", longint'(busy), 0);
    chk(out_valid == 1'b0, "R1", "out_valid at reset", longint'(out_valid), 0);
    for (int k = 0; k < 4; k++) begin
      m_brk[k] = 0; m_slope[k] = 256; m_ofs[k] = 0;
    end
    for (int i = 0; i < 16; i++) m_acc[i] = 0;
    run_layer("R1", 1'b0);
  endtask

  task automatic t_mode16;
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i * 2300 - 17000);
    do_step(3, 16'd3, 1'b0, 0);
    do_step(3, 16'hFFFB, 1'b0, 0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i * 3 - 20);
    do_step(3, 16'd1200, 1'b0, 0);
    run_layer("R1 R2", 1'b0);
  endtask

  task automatic t_feedback;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i - 7);
    do_step(3, 16'h1234, 1'b1, 3);
    do_step(3, 16'h0000, 1'b1, 10);
    run_layer("R11", 1'b0);
  endtask

  task automatic t_mode8;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++)
      weights[i*16 +: 16] = {8'(i * 7 - 50), 8'(100 - i * 13)};
    do_step(2, 16'hFD05, 1'b0, 0);
    do_step(2, 16'h7F80, 1'b0, 0);
    run_layer("R3", 1'b0);
  endtask

  task automatic t_mode4;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i * 16'h1357) ^ 16'hA5C3;
    do_step(1, 16'h8F71, 1'b0, 0);
    do_step(1, 16'h3C9E, 1'b0, 0);
    run_layer("R4", 1'b0);
  endtask

  task automatic t_mode1;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'((32'h1 << (i + 1)) - 1);
    do_step(0, 16'hFFFF, 1'b0, 0);
    do_step(0, 16'h5A5A, 1'b0, 0);
    do_step(0, 16'h8001, 1'b0, 0);
    run_layer("R5", 1'b0);
  endtask

  task automatic t_saturate;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
    for (int s = 0; s < 3; s++) do_step(3, 16'h8000, 1'b0, 0);
    run_layer("R6", 1'b0);
  endtask

  task automatic t_clear;
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i + 1);
    do_step(3, 16'd500, 1'b0, 0);
    do_clr(1'b1);
    run_layer("R7", 1'b0);
  endtask

  task automatic t_busy;
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i * 97 - 700);
    do_step(3, 16'd21, 1'b0, 0);
    run_layer("R10", 1'b1);
    run_layer("R10", 1'b0);
  endtask

  task automatic t_pwl;
    do_clr(1'b0);
    for (int i = 0; i < 16; i++) weights[i*16 +: 16] = 16'(i * 4000 - 30000);
    do_step(3, 16'd1, 1'b0, 0);
    cfg_write(0, -1000000, 128, -20000);
    cfg_write(1, -10000, 256, -9000);
    cfg_write(2, 0, 768, 500);
    cfg_write(3, 20000, -64, 30000);
    run_layer("R8", 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode16();
    t_feedback();
    t_mode8();
    t_mode4();
    t_mode1();
    t_saturate();
    t_clear();
    t_busy();
    t_pwl();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule